// File: doc/BRIEF.md
# Edge-Latching Cascade Interrupt Collector

This block gathers rising-edge events from a parameterised set of source lines (up to the data width, 32 by default) and presents them to a parent interrupt controller as one level-sensitive request line. Each source is first brought into the local clock domain through a short synchronizer chain. A 0-to-1 transition then sets a sticky pending bit, which stays set until software acknowledges it.

Pending bits are captured whether or not the source is enabled. An enable register decides which pending bits are allowed to raise the request line. Because of this, software should clear any stale pending bit before it enables a source. A pending bit is acknowledged by writing 0 to it, and writing 1 leaves a bit as it was, so a handler can clear exactly one source with a single write. Clearing both registers puts the block into a fully disabled, idle state.

Top module: `edge_irq_collector`

## Requirements
- R1: After a synchronous reset, the pending register (offset 0x00), the enable register (offset 0x04) and `irq_o` are all zero.
- R2: A rising edge on `src_i[i]` sets pending bit i. The bit stays set after the source falls again and until software clears it.
- R3: Only a 0-to-1 transition of the synchronized source sets a pending bit. A source that stays high, or that falls, does not set it again once it has been cleared.
- R4: A pending bit is set by an edge even while its enable bit is 0.
- R5: A write to offset 0x00 clears each pending bit whose data bit is 0 and leaves each pending bit whose data bit is 1 unchanged.
- R6: When an edge arrives for bit i in the same cycle that a write clears bit i, the bit ends up set.
- R7: The enable register at offset 0x04 holds the value last written to it and reads it back.
- R8: `irq_o` is 1 exactly when some bit is both pending and enabled, and it follows a change of either register with no added cycle.
- R9: Register bits at positions NUM_SRC and above read as 0, and writes to them have no effect.
- R10: Reads from any offset other than 0x00 and 0x04 return 0, and writes to such an offset change neither register.
- R11: A source that rises just before clock edge k sets its pending bit at edge k+2 (two synchronizer stages, then the capture register) and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NUM_SRC | Asynchronous event source lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq_o | output | 1 | Level request to the parent controller |

## Verification
The bench builds the block with NUM_SRC = 20, which is narrower than the 32-bit data path. This leaves twelve unimplemented bit positions, so the zero read-back and ignored writes in the upper bits can be checked. The default of two synchronizer stages lets the bench check the exact cycle in which a pending bit first appears. It also lets the bench schedule a clearing write so that it lands in the same cycle as an edge, which tests the set-over-clear priority.

// File: rtl/eib_pkg.sv
// Package: shared register offsets and access decode for the edge-latching
// interrupt collector. Assumes byte offsets and word-aligned registers.
package eib_pkg;
    localparam int PEND_OFS = 'h00;
    localparam int ENAB_OFS = 'h04;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_PEND = 2'd1,
        ACC_ENAB = 2'd2
    } eib_acc_e;

    // Map a byte offset onto the register it selects.
    function automatic eib_acc_e eib_decode(input logic [31:0] ofs);
        if (ofs == 32'(PEND_OFS))      return ACC_PEND;
        else if (ofs == 32'(ENAB_OFS)) return ACC_ENAB;
        else                           return ACC_NONE;
    endfunction
endpackage

// File: rtl/eib_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous lines.
// Assumes each line is independent; no bus coherency across bits.
module eib_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw inputs into the first flop row.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Shift the previous row forward one stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/eib_edge.sv
// Module: rising-edge detector. Compares each synchronized line with its
// value one cycle earlier and flags a 0-to-1 step for one cycle.
// Assumes inputs are already in the local clock domain.
module eib_edge #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    // Remember last cycle's level of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    // Flag lines that are high now and were low before.
    always_comb rise_o = lvl_i & ~prev_q;

    // R3
    no_double_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/eib_regs.sv
// Module: pending (sticky, write-0-to-clear) and enable registers.
// An edge in the same cycle as a clearing write keeps its bit set.
// Assumes the write strobes are mutually exclusive.
module eib_regs #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise_i,
    input  logic             pend_we,
    input  logic             enab_we,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] pend_o,
    output logic [WIDTH-1:0] enab_o
);
    logic [WIDTH-1:0] pend_q, enab_q;
    logic [WIDTH-1:0] keep_mask;

    // Bits written as 0 are dropped, all others are kept.
    always_comb keep_mask = pend_we ? wdata_i : '1;

    // Pending bits: clear on written 0, new edges set with priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & keep_mask) | rise_i;
    end

    // Enable bits: plain load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)       enab_q <= '0;
        else if (enab_we) enab_q <= wdata_i;
    end

    assign pend_o = pend_q;
    assign enab_o = enab_q;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));

    // R5
    clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_q) & ~pend_q) != '0) |-> $past(pend_we));

    // R2
    set_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(rise_i)) == '0));
endmodule

// File: rtl/edge_irq_collector.sv
// Module: top of the edge-latching interrupt collector. Synchronizes the
// sources, detects rising edges, keeps pending/enable registers behind a
// simple strobe bus and drives one level request to a parent controller.
// Assumes 1 <= NUM_SRC <= DATA_W and a single-cycle register access.
module edge_irq_collector
    import eib_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);
    localparam int SRC_W = NUM_SRC;

    logic [SRC_W-1:0] src_sync, src_rise;
    logic [SRC_W-1:0] pend, enab;
    eib_acc_e         acc;
    logic             pend_we, enab_we;
    logic             wdata_parity;

    eib_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(src_i), .sync_o(src_sync));

    eib_edge #(.WIDTH(SRC_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(src_sync), .rise_o(src_rise));

    // Decode which register the bus targets.
    always_comb acc = eib_decode(32'(bus_addr));

    // Form the write strobes.
    always_comb begin
        pend_we = bus_sel && bus_wr && (acc == ACC_PEND);
        enab_we = bus_sel && bus_wr && (acc == ACC_ENAB);
    end

    eib_regs #(.WIDTH(SRC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .rise_i(src_rise),
        .pend_we(pend_we), .enab_we(enab_we),
        .wdata_i(bus_wdata[SRC_W-1:0]),
        .pend_o(pend), .enab_o(enab));

    // Read mux, unimplemented bits and offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (acc)
            ACC_PEND: bus_rdata[SRC_W-1:0] = pend;
            ACC_ENAB: bus_rdata[SRC_W-1:0] = enab;
            default:  bus_rdata = '0;
        endcase
    end

    // Level request: any enabled pending bit.
    always_comb irq_o = |(pend & enab);

    // Upper write-data bits feed nothing; fold them into one unused net.
    always_comb wdata_parity = ^bus_wdata;

    // R8
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(src_rise != '0) || $past(enab_we)));

    // R8
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(pend_we) || $past(enab_we)));
endmodule

// File: tb/sim_edge_irq_collector.sv
module sim_edge_irq_collector;
    localparam int PERIOD = 10;
    localparam int NSRC   = 20;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int NVEC   = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0;
    logic            bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic            irq_o;

    int errors = 0, checks = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    edge_irq_collector #(.NUM_SRC(NSRC), .DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o));

    // Vector fields: write flag, offset, data, expected read, tag.
    localparam logic         V_WR  [NVEC] = '{1, 0, 1, 0, 1, 0, 0, 0, 1, 0};
    localparam logic [7:0]   V_ADR [NVEC] = '{8'h04, 8'h04, 8'h04, 8'h04, 8'h08,
                                              8'h08, 8'h04, 8'h00, 8'h04, 8'h04};
    localparam logic [31:0]  V_DAT [NVEC] = '{32'hFFFF_FFFF, 0, 32'h0000_0A5A, 0,
                                              32'hFFFF_FFFF, 0, 0, 0, 0, 0};
    localparam logic [31:0]  V_EXP [NVEC] = '{0, 32'h000F_FFFF, 0, 32'h0000_0A5A,
                                              0, 0, 32'h0000_0A5A, 0, 0, 0};
    localparam logic [23:0]  V_TAG [NVEC] = '{"R9", "R9", "R7", "R7", "R10",
                                              "R10", "R10", "R10", "R7", "R7"};

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Starts at a negedge, ends at the next negedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        cyc(3);
        rst_n = 1;
        // R1 reset state
        rd(8'h00, r); check("R1", r, 0);
        rd(8'h04, r); check("R1", r, 0);
        check("R1", {31'b0, irq_o}, 0);

        // Table walk: register access vectors
        for (int v = 0; v < NVEC; v++) begin
            if (V_WR[v]) wr(V_ADR[v], V_DAT[v]);
            else begin
                rd(V_ADR[v], r);
                check($sformatf("%s", V_TAG[v]), r, V_EXP[v]);
                @(negedge clk);
            end
        end

        // R11 latency and R2 capture; R4 while disabled
        src_i[3] = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(8'h00, r); check("R11", r, 0);
        @(posedge clk); @(negedge clk);
        rd(8'h00, r); check("R11", r, 32'h8);
        check("R4", {31'b0, irq_o}, 0);
        src_i[3] = 0; cyc(4);
        rd(8'h00, r); check("R2", r, 32'h8);

        // R8 enable raises the request
        wr(8'h04, 32'h8);
        check("R8", {31'b0, irq_o}, 1);

        // R5 selective clear
        src_i[5] = 1; cyc(4); src_i[5] = 0; cyc(2);
        rd(8'h00, r); check("R5", r, 32'h28);
        wr(8'h00, ~32'h8);
        rd(8'h00, r); check("R5", r, 32'h20);
        check("R8", {31'b0, irq_o}, 0);

        // R3 held-high source does not re-latch
        src_i[7] = 1; cyc(4);
        wr(8'h00, ~32'h80);
        cyc(5);
        rd(8'h00, r); check("R3", r, 32'h20);
        src_i[7] = 0; cyc(5);
        rd(8'h00, r); check("R3", r, 32'h20);

        // R6 set wins over a clear in the same cycle
        src_i[9] = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(8'h00, 32'h0);
        rd(8'h00, r); check("R6", r, 32'h200);
        src_i[9] = 0;

        // R9 upper pending bits stay zero
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, r); check("R9", r, 32'h200);

        // R8 enable on a pending bit, then R1 reset clears everything
        wr(8'h04, 32'h200);
        check("R8", {31'b0, irq_o}, 1);
        rst_n = 0; cyc(2); rst_n = 1;
        rd(8'h00, r); check("R1", r, 0);
        rd(8'h04, r); check("R1", r, 0);
        check("R1", {31'b0, irq_o}, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule